// File: doc/BRIEF.md
# Pipelined Restoring Integer Divider

This block divides an unsigned dividend by an unsigned divisor and returns both the quotient and the remainder. It uses restoring shift-and-subtract division. In each iteration a trial difference between the running partial remainder and the divisor decides one quotient bit. That decision also decides whether the difference or the old remainder moves on. Dividend bits are consumed from the most significant end.

Every iteration is unrolled into combinational logic, and the chain is cut into three register stages. The block therefore takes a new operand pair on every clock when the input strobe is high. Each result leaves the block exactly three cycles later, with its own output strobe.

Division by zero raises no exception. It gives a fixed answer: every quotient bit set, and the dividend returned as the remainder.

Top module: `pipe_restoring_div`

## Requirements
- R1: For a nonzero divisor, `q_out` equals the integer floor of `dvd_in / dvs_in`.
- R2: For a nonzero divisor, `rem_out` equals `dvd_in - dvs_in * q_out`, which is strictly less than the divisor.
- R3: `q_out` is one bit wider than the dividend. Its most significant bit (bit `DVD_W`) is 0 whenever the divisor is nonzero.
- R4: When `in_vld` is high in clock cycle c, `out_vld` is high in cycle c+3, and the result of that operand pair is on `q_out`/`rem_out` in the same cycle.
- R5: Operand pairs presented on consecutive cycles are all accepted. Their results appear on consecutive cycles, in the order the pairs were presented.
- R6: With a divisor of zero, `q_out` has all `DVD_W+1` bits set to 1, and `rem_out` equals the dividend.
- R7: `rst` is synchronous and active high, and it clears every stage valid flag. `out_vld` stays low while `rst` is held. Operands presented during reset produce no result after `rst` is released.
- R8: A cycle with `in_vld` low produces no result: `out_vld` is low three cycles later, and no extra result appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_vld | input | 1 | Operand pair on the inputs is valid this cycle |
| dvd_in | input | DVD_W | Unsigned dividend |
| dvs_in | input | DVS_W | Unsigned divisor |
| out_vld | output | 1 | Result on the outputs is valid this cycle |
| q_out | output | DVD_W+1 | Quotient |
| rem_out | output | DVD_W | Remainder (equals the dividend when the divisor is zero) |

## Verification
Two things can fall in the same cycle. A new operand pair enters the first stage while an older result leaves the third stage. A divide-by-zero pair can also sit in the pipeline next to ordinary pairs. The bench provokes both with back-to-back bursts that mix zero and nonzero divisors, and with random gaps between pairs. A scoreboard judges every result against its own arithmetic model and checks that the result emerges exactly three cycles after its pair went in. Any result that arrives with no pending entry counts as a failure.

// File: rtl/prd_pkg.sv
package prd_pkg;

    // Number of restoring iterations placed in pipeline stage idx (0..2).
    // Leftover iterations go to the earliest stages.
    function automatic int stage_len(input int total, input int idx);
        int base;
        int extra;
        base  = total / 3;
        extra = total % 3;
        return base + ((idx < extra) ? 1 : 0);
    endfunction

    // First global iteration index handled by stage idx.
    function automatic int stage_first(input int total, input int idx);
        int acc;
        acc = 0;
        for (int s = 0; s < idx; s++) begin
            acc += stage_len(total, s);
        end
        return acc;
    endfunction

endpackage

// File: rtl/prd_step.sv
module prd_step #(
    parameter int  DVD_W   = 16,
    parameter int  DVS_W   = 9,
    parameter bit  IS_LAST = 1'b0
) (
    input  logic [DVD_W-1:0] rem_i,
    input  logic             nb_i,
    input  logic [DVS_W-1:0] dvs_i,
    output logic [DVD_W-1:0] rem_o,
    output logic             qbit_o
);

    localparam int PAD_W = DVD_W + 1 - DVS_W;

    logic signed [DVD_W:0] trial;

    assign trial = $signed({1'b0, rem_i}) - $signed({{PAD_W{1'b0}}, dvs_i});

    always_comb begin
        if (trial[DVD_W]) begin
            qbit_o = 1'b0;
            if (IS_LAST) rem_o = rem_i;
            else         rem_o = {rem_i[DVD_W-2:0], nb_i};
        end else begin
            qbit_o = 1'b1;
            if (IS_LAST) rem_o = trial[DVD_W-1:0];
            else         rem_o = {trial[DVD_W-2:0], nb_i};
        end
    end

endmodule

// File: rtl/prd_stage.sv
module prd_stage #(
    parameter int DVD_W = 16,
    parameter int DVS_W = 9,
    parameter int FIRST = 0,
    parameter int COUNT = 6,
    parameter int ITER  = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [DVD_W-1:0] in_rem,
    input  logic [DVD_W:0]   in_quo,
    input  logic [DVD_W-1:0] in_dvd,
    input  logic [DVS_W-1:0] in_dvs,
    output logic             out_vld,
    output logic [DVD_W-1:0] out_rem,
    output logic [DVD_W:0]   out_quo,
    output logic [DVD_W-1:0] out_dvd,
    output logic [DVS_W-1:0] out_dvs
);

    typedef struct packed {
        logic             vld;
        logic [DVD_W-1:0] rem;
        logic [DVD_W:0]   quo;
        logic [DVD_W-1:0] dvd;
        logic [DVS_W-1:0] dvs;
    } stg_t;

    stg_t stg_d;
    stg_t stg_q;

    logic [DVD_W-1:0] rem_c [COUNT+1];
    logic [COUNT-1:0] qbit;

    assign rem_c[0] = in_rem;

    for (genvar k = 0; k < COUNT; k++) begin : g_step
        localparam int G    = FIRST + k;
        localparam bit LAST = (G == ITER - 1);
        localparam int BI   = LAST ? 0 : (DVD_W - 1 - G);
        logic nb;
        if (LAST) begin : g_nb_last
            assign nb = 1'b0;
        end else begin : g_nb_bit
            assign nb = in_dvd[BI];
        end
        prd_step #(
            .DVD_W  (DVD_W),
            .DVS_W  (DVS_W),
            .IS_LAST(LAST)
        ) u_step (
            .rem_i (rem_c[k]),
            .nb_i  (nb),
            .dvs_i (in_dvs),
            .rem_o (rem_c[k+1]),
            .qbit_o(qbit[k])
        );
    end

    always_comb begin
        stg_d.vld = in_vld;
        stg_d.rem = rem_c[COUNT];
        stg_d.quo = in_quo;
        for (int k = 0; k < COUNT; k++) begin
            stg_d.quo[DVD_W-FIRST-k] = qbit[k];
        end
        stg_d.dvd = in_dvd;
        stg_d.dvs = in_dvs;
    end

    always_ff @(posedge clk) begin
        if (rst) stg_q.vld <= 1'b0;
        else     stg_q.vld <= stg_d.vld;
        stg_q.rem <= stg_d.rem;
        stg_q.quo <= stg_d.quo;
        stg_q.dvd <= stg_d.dvd;
        stg_q.dvs <= stg_d.dvs;
    end

    assign out_vld = stg_q.vld;
    assign out_rem = stg_q.rem;
    assign out_quo = stg_q.quo;
    assign out_dvd = stg_q.dvd;
    assign out_dvs = stg_q.dvs;

    // R4
    vld_advance_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (stg_q.vld == $past(in_vld)));

    // R7
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> !stg_q.vld);

endmodule

// File: rtl/pipe_restoring_div.sv
module pipe_restoring_div #(
    parameter int DVD_W = 16,
    parameter int DVS_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [DVD_W-1:0] dvd_in,
    input  logic [DVS_W-1:0] dvs_in,
    output logic             out_vld,
    output logic [DVD_W:0]   q_out,
    output logic [DVD_W-1:0] rem_out
);

    localparam int ITER = DVD_W + 1;
    localparam int NSTG = 3;

    logic             s_vld [NSTG+1];
    logic [DVD_W-1:0] s_rem [NSTG+1];
    logic [DVD_W:0]   s_quo [NSTG+1];
    logic [DVD_W-1:0] s_dvd [NSTG+1];
    logic [DVS_W-1:0] s_dvs [NSTG+1];

    assign s_vld[0] = in_vld;
    assign s_rem[0] = '0;
    assign s_quo[0] = '0;
    assign s_dvd[0] = dvd_in;
    assign s_dvs[0] = dvs_in;

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        prd_stage #(
            .DVD_W(DVD_W),
            .DVS_W(DVS_W),
            .FIRST(prd_pkg::stage_first(ITER, s)),
            .COUNT(prd_pkg::stage_len(ITER, s)),
            .ITER (ITER)
        ) u_stage (
            .clk    (clk),
            .rst    (rst),
            .in_vld (s_vld[s]),
            .in_rem (s_rem[s]),
            .in_quo (s_quo[s]),
            .in_dvd (s_dvd[s]),
            .in_dvs (s_dvs[s]),
            .out_vld(s_vld[s+1]),
            .out_rem(s_rem[s+1]),
            .out_quo(s_quo[s+1]),
            .out_dvd(s_dvd[s+1]),
            .out_dvs(s_dvs[s+1])
        );
    end

    assign out_vld = s_vld[NSTG];
    assign q_out   = s_quo[NSTG];
    assign rem_out = s_rem[NSTG];

    logic [DVD_W+DVS_W:0] recon;
    assign recon = ({{DVS_W{1'b0}}, q_out} * {{(DVD_W+1){1'b0}}, s_dvs[NSTG]})
                 + {{(DVS_W+1){1'b0}}, rem_out};

    // R1
    recon_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && s_dvs[NSTG] != '0) |-> (recon == {{(DVS_W+1){1'b0}}, s_dvd[NSTG]}));

    // R2
    rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && s_dvs[NSTG] != '0) |-> ({1'b0, rem_out} < {{(DVD_W+1-DVS_W){1'b0}}, s_dvs[NSTG]}));

    // R3
    q_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && s_dvs[NSTG] != '0) |-> !q_out[DVD_W]);

    // R6
    zero_div_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && s_dvs[NSTG] == '0) |-> (&q_out && rem_out == s_dvd[NSTG]));

endmodule

// File: tb/tb_pipe_restoring_div.sv
module tb_pipe_restoring_div;

    localparam int DVD_W = 16;
    localparam int DVS_W = 9;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_vld = 1'b0;
    logic [DVD_W-1:0] dvd_in = '0;
    logic [DVS_W-1:0] dvs_in = '0;
    logic             out_vld;
    logic [DVD_W:0]   q_out;
    logic [DVD_W-1:0] rem_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int sent = 0;
    int seen = 0;

    typedef struct {
        logic [DVD_W:0]   q;
        logic [DVD_W-1:0] r;
        int               cyc;
        bit               zdiv;
    } exp_t;

    exp_t sb[$];

    pipe_restoring_div #(.DVD_W(DVD_W), .DVS_W(DVS_W)) dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .dvd_in(dvd_in), .dvs_in(dvs_in),
        .out_vld(out_vld), .q_out(q_out), .rem_out(rem_out)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Driver: one operand pair per call, presented for one cycle.
    task automatic send(input int a, input int b);
        exp_t e;
        @(negedge clk);
        in_vld = 1'b1;
        dvd_in = a[DVD_W-1:0];
        dvs_in = b[DVS_W-1:0];
        if (b == 0) begin
            e.q = '1;
            e.r = a[DVD_W-1:0];
            e.zdiv = 1'b1;
        end else begin
            e.q = (DVD_W+1)'(a / b);
            e.r = DVD_W'(a % b);
            e.zdiv = 1'b0;
        end
        e.cyc = cyc;
        sb.push_back(e);
        sent++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
            dvd_in = DVD_W'($urandom);
            dvs_in = DVS_W'($urandom);
        end
    endtask

    // Monitor: pops the scoreboard whenever a result appears.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (out_vld) begin
                seen++;
                if (sb.size() == 0) begin
                    check(1'b0, "R8 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(q_out === e.q, e.zdiv ? "R6 quotient" : "R1 quotient", longint'(q_out), longint'(e.q));
                    check(rem_out === e.r, e.zdiv ? "R6 remainder" : "R2 remainder", longint'(rem_out), longint'(e.r));
                    check(cyc == e.cyc + 3, "R4 latency", cyc - e.cyc, 3);
                    if (!e.zdiv) check(q_out[DVD_W] === 1'b0, "R3 quotient msb", longint'(q_out[DVD_W]), 0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog expired, results outstanding=%0d expected=0", sb.size());
        summary();
        $finish;
    end

    initial begin
        // R7: operands offered while reset is held must not emerge.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_vld = 1'b1;
            dvd_in = DVD_W'(100 + i);
            dvs_in = DVS_W'(3);
            #1 check(out_vld === 1'b0, "R7 out_vld during reset", longint'(out_vld), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        in_vld = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            #1 check(out_vld === 1'b0, "R7 out_vld after reset release", longint'(out_vld), 0);
        end

        // R1 R2: listed corner cases, with idle cycles between them (R8).
        send(65535, 1);   idle(2);
        send(2, 511);     idle(1);
        send(65535, 511); idle(3);
        send(8, 1);       idle(1);
        send(99, 10);     idle(5);

        // R8: a bubble between pairs yields a gap in results.
        send(1000, 7);
        idle(1);
        send(1001, 7);
        idle(1);
        @(negedge clk);
        #1;
        idle(6);

        // R6: division by zero, alone and mixed into a burst (R5).
        send(0, 0);     idle(4);
        send(65535, 0); idle(4);
        send(500, 3);
        send(1234, 0);
        send(1234, 1);
        send(0, 511);
        send(65534, 2);
        send(511, 511);
        send(510, 511);
        idle(6);

        // R5: long back-to-back random burst.
        for (int i = 0; i < 200; i++) begin
            int b;
            b = (i % 17 == 0) ? 0 : int'($urandom_range(1, 511));
            send(int'($urandom_range(0, 65535)), b);
        end
        idle(6);

        // R8: random sparse traffic.
        for (int i = 0; i < 300; i++) begin
            send(int'($urandom_range(0, 65535)), int'($urandom_range(0, 511)));
            if ($urandom_range(0, 2) == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(8);

        check(sb.size() == 0, "R5 results outstanding", sb.size(), 0);
        check(seen == sent, "R8 result count", seen, sent);
        summary();
        $finish;
    end

endmodule